// File: doc/BRIEF.md
# Table Pointer Byte Access Unit

This unit gives a processor core byte-wide access to its 16-bit program memory through a byte-address pointer and an 8-bit holding latch. The core hands it any opcode it has fetched. The unit acts on the eight table-access opcodes: four read forms and four write forms. A read copies one byte of the addressed program word into the latch. A write presents the latch contents to memory as one byte of the addressed word.

The two low opcode bits select how the pointer moves around the access. The same choice applies to reads and to writes. The pointer can stay where it is, advance after the access, step back after the access, or advance before the access so that the access uses the advanced value.

Every table instruction takes two cycles. In the cycle after acceptance the unit issues one memory request and holds `stall` high. When a write lands on the high byte of a word, it starts the memory's internal programming cycle. `busy` then stays high, and the core stays stalled, until the memory reports completion on `mem_done`.

Top module: `tblptr_unit`

## Requirements
- R1: After reset, `ptr` and `latch` are zero, and `stall`, `busy`, `mem_req` and `mem_we` are low.
- R2: An `issue` with `opcode` in 0x0008..0x000F is accepted when `stall` is low. Opcode bit 2 clear means a read and set means a write. An `issue` with any other opcode changes no output.
- R3: The pointer update is chosen by opcode bits [1:0]. The value 00 leaves the pointer unchanged, 01 adds one, 10 subtracts one, and 11 adds one. The pointer is 22 bits wide and wraps modulo 2^22.
- R4: Mode 11 accesses the already-incremented pointer, and every other mode accesses the pointer as it was before the update. `mem_addr` carries the accessed pointer's bits [21:1]. `mem_hi` carries its bit 0, where 1 selects bits [15:8] of the word and 0 selects bits [7:0].
- R5: An accepted instruction raises `mem_req` (with `stall`) in exactly the next cycle and only for that cycle. Two requests are never in adjacent cycles.
- R6: On a read, the latch takes the selected byte of `mem_rdata` at the end of the request cycle.
- R7: On a write, the request cycle has `mem_we` high and `mem_wdata` equal to the latch.
- R8: A write with `mem_hi` = 1 sets `busy` from the next cycle. `busy` clears in the cycle after `mem_done` is seen high. `mem_done` has no effect while `busy` is low.
- R9: While `busy` is high, `stall` is high and no table instruction is accepted. A held instruction is accepted once `busy` falls.
- R10: `ptr_load` and `latch_load` take effect only while `stall` is low. An accepted table instruction takes precedence over `ptr_load` in the same cycle. Both loads are ignored while stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Opcode valid from the core |
| opcode | input | 16 | Instruction word |
| ptr_load | input | 1 | Direct pointer load strobe |
| ptr_in | input | 22 | Direct pointer value |
| latch_load | input | 1 | Direct latch load strobe |
| latch_in | input | 8 | Direct latch value |
| mem_rdata | input | 16 | Program word returned for `mem_addr` in the request cycle |
| mem_done | input | 1 | Internal write cycle finished |
| ptr | output | 22 | Current table pointer |
| latch | output | 8 | Table data latch |
| stall | output | 1 | Core must hold its pipeline |
| busy | output | 1 | Internal memory write in progress |
| mem_req | output | 1 | Memory request this cycle |
| mem_we | output | 1 | Request is a byte write |
| mem_addr | output | 21 | Program word address |
| mem_hi | output | 1 | High byte selected |
| mem_wdata | output | 8 | Write byte |

## Verification
The assertions assume that the memory returns `mem_rdata` combinationally within the request cycle. They also assume that `mem_done` comes as a pulse while `busy` is high. The checks still allow `mem_done` at any other time, because the unit must ignore it then. The stimulus holds a table opcode on `issue` until it is accepted, as a stalled core would. A responder answers reads from a word array and raises `mem_done` a few cycles after `busy` rises. In one phase of the run the responder also drives `mem_done` while the unit is idle. Direct loads are pulsed during stalls on purpose, to exercise the rule that they are ignored while stalled.

// File: rtl/tblptr_unit.sv
module tblptr_unit #(
  parameter int PW = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [15:0]   opcode,
  input  logic          ptr_load,
  input  logic [PW-1:0] ptr_in,
  input  logic          latch_load,
  input  logic [7:0]    latch_in,
  input  logic [15:0]   mem_rdata,
  input  logic          mem_done,
  output logic [PW-1:0] ptr,
  output logic [7:0]    latch,
  output logic          stall,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [PW-2:0] mem_addr,
  output logic          mem_hi,
  output logic [7:0]    mem_wdata
);
  localparam logic [PW-1:0] ONE = PW'(1);

  logic          phase, wr;
  logic [PW-1:0] acc, ptr_nxt;
  logic [1:0]    mode;
  logic          accept;

  assign mode   = opcode[1:0];
  assign accept = issue && (opcode[15:4] == 12'h000) && opcode[3] && !stall;

  always_comb begin
    case (mode)
      2'b01, 2'b11: ptr_nxt = ptr + ONE;
      2'b10:        ptr_nxt = ptr - ONE;
      default:      ptr_nxt = ptr;
    endcase
  end

  assign stall     = phase | busy;
  assign mem_req   = phase;
  assign mem_we    = phase & wr;
  assign mem_addr  = acc[PW-1:1];
  assign mem_hi    = acc[0];
  assign mem_wdata = latch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr   <= '0;
      acc   <= '0;
      wr    <= 1'b0;
      phase <= 1'b0;
    end else if (accept) begin
      ptr   <= ptr_nxt;
      acc   <= (mode == 2'b11) ? ptr_nxt : ptr;
      wr    <= opcode[2];
      phase <= 1'b1;
    end else begin
      phase <= 1'b0;
      if (ptr_load && !stall) ptr <= ptr_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      latch <= '0;
    else if (phase && !wr)
      latch <= acc[0] ? mem_rdata[15:8] : mem_rdata[7:0];
    else if (latch_load && !stall)
      latch <= latch_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      busy <= 1'b0;
    else if (phase && wr && acc[0])
      busy <= 1'b1;
    else if (busy && mem_done)
      busy <= 1'b0;
  end

  a_r5_req_follows: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> mem_req);
  a_r5_single_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  a_r8_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(mem_req && mem_we && mem_hi));
  a_r8_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_done) |=> busy);
  a_r9_busy_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> stall);
  a_r3_post_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode == 2'b01) |=> ptr == $past(ptr) + ONE);
  a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(ptr));
endmodule

// File: tb/tblptr_unit_bench.sv
module tblptr_unit_bench;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic        issue = 0, ptr_load = 0, latch_load = 0, mem_done = 0;
  logic [15:0] opcode = 0, mem_rdata;
  logic [21:0] ptr_in = 0, ptr;
  logic [7:0]  latch_in = 0, latch, mem_wdata;
  logic        stall, busy, mem_req, mem_we, mem_hi;
  logic [20:0] mem_addr;

  tblptr_unit u_tblptr_unit (.*);

  int total = 0, bad = 0;
  bit done_noise = 0;
  int dcnt = 0;

  logic [15:0] rmem [int];
  logic [15:0] mmem [int];

  function automatic logic [15:0] seed(int a);
    return 16'(a * 16'h1357) ^ 16'hA5C3;
  endfunction

  // memory responder
  always_comb mem_rdata = rmem.exists(int'(mem_addr)) ? rmem[int'(mem_addr)] : seed(int'(mem_addr));
  always @(posedge clk) if (mem_req && mem_we) begin
    logic [15:0] w;
    w = rmem.exists(int'(mem_addr)) ? rmem[int'(mem_addr)] : seed(int'(mem_addr));
    if (mem_hi) w[15:8] = mem_wdata; else w[7:0] = mem_wdata;
    rmem[int'(mem_addr)] = w;
  end
  always @(negedge clk) begin
    if (busy) begin dcnt++; mem_done = (dcnt >= 3); end
    else begin dcnt = 0; mem_done = done_noise; end
  end

  // reference model
  logic [21:0] m_ptr = 0, m_acc = 0;
  logic [7:0]  m_latch = 0;
  bit m_phase = 0, m_wr = 0, m_busy = 0, m_took = 0;
  always @(posedge clk) begin
    bit st, acc_ok;
    st = m_phase || m_busy;
    acc_ok = issue && opcode[15:4] == 0 && opcode[3] && !st;
    m_took = acc_ok;
    if (!rst_n) begin
      m_ptr = 0; m_acc = 0; m_latch = 0; m_phase = 0; m_wr = 0; m_busy = 0;
    end else begin
      if (m_busy && mem_done) m_busy = 0;
      if (m_phase) begin
        int wa; logic [15:0] w;
        wa = int'(m_acc >> 1);
        w = mmem.exists(wa) ? mmem[wa] : seed(wa);
        if (!m_wr) m_latch = m_acc[0] ? w[15:8] : w[7:0];
        else begin
          if (m_acc[0]) w[15:8] = m_latch; else w[7:0] = m_latch;
          mmem[wa] = w;
          if (m_acc[0]) m_busy = 1;
        end
      end else if (latch_load && !st) m_latch = latch_in;
      m_phase = 0;
      if (acc_ok) begin
        int p;
        p = int'(m_ptr);
        case (opcode[1:0])
          2'b01, 2'b11: p = p + 1;
          2'b10: p = p - 1;
          default: ;
        endcase
        m_acc = (opcode[1:0] == 2'b11) ? 22'(p) : m_ptr;
        m_ptr = 22'(p);
        m_wr = opcode[2];
        m_phase = 1;
      end else if (ptr_load && !st) m_ptr = ptr_in;
    end
  end

  task automatic chk(string rq, string nm, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", rq, nm, act, exp, $time);
    end
  endtask

  bit run_cmp = 0;
  always @(negedge clk) if (run_cmp) begin
    chk("R3", "ptr", ptr, m_ptr);
    chk("R6", "latch", latch, m_latch);
    chk("R5", "stall", stall, m_phase || m_busy);
    chk("R8", "busy", busy, m_busy);
    chk("R5", "mem_req", mem_req, m_phase);
    chk("R7", "mem_we", mem_we, m_phase && m_wr);
    if (m_phase) begin
      chk("R4", "mem_addr", mem_addr, m_acc[21:1]);
      chk("R4", "mem_hi", mem_hi, m_acc[0]);
      if (m_wr) chk("R7", "mem_wdata", mem_wdata, m_latch);
    end
  end

  task automatic run_op(logic [15:0] op);
    @(negedge clk); issue = 1; opcode = op;
    do @(negedge clk); while (!m_took);
    issue = 0; opcode = 0;
  endtask
  task automatic ld_ptr(logic [21:0] v);
    @(negedge clk); ptr_load = 1; ptr_in = v;
    @(negedge clk); ptr_load = 0;
  endtask
  task automatic ld_latch(logic [7:0] v);
    @(negedge clk); latch_load = 1; latch_in = v;
    @(negedge clk); latch_load = 0;
  endtask
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  int cyc = 0;
  bit timed_out = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !timed_out) begin
      timed_out = 1; bad++; total++;
      $display("FAIL watchdog actual=%0d expected<50000", cyc);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "ptr", ptr, 0); chk("R1", "latch", latch, 0);
    chk("R1", "stall", stall, 0); chk("R1", "busy", busy, 0);
    chk("R1", "mem_req", mem_req, 0); chk("R1", "mem_we", mem_we, 0);
    rst_n = 1; run_cmp = 1;
    ld_ptr(22'h000100); ld_latch(8'h5A);
    run_op(16'h0008); idle(2);            // R3 mode 00, R6 read low byte
    run_op(16'h0009); run_op(16'h0009);   // R3 post-inc, R4 high byte
    run_op(16'h000A); run_op(16'h000B);   // R3 post-dec, R4 pre-inc
    @(negedge clk); issue = 1; opcode = 16'h0007; idle(3); issue = 0; // R2 other opcode
    opcode = 16'h1008; issue = 1; idle(2); issue = 0;                  // R2 high bits set
    ld_ptr(22'h3FFFFF); run_op(16'h000B); idle(2);  // R3 wrap up
    ld_ptr(22'h000000); run_op(16'h000A); idle(2);  // R3 wrap down
    // R10 ptr_load with accepted instruction in same cycle
    @(negedge clk); issue = 1; opcode = 16'h0009; ptr_load = 1; ptr_in = 22'h1234;
    @(negedge clk); issue = 0; ptr_load = 0; latch_load = 1; latch_in = 8'hEE; // stalled: ignored
    @(negedge clk); latch_load = 0; idle(2);
    // writes: R7, R8, R9
    ld_ptr(22'h000200); ld_latch(8'h11);
    run_op(16'h000D);                     // low byte, no busy
    ld_latch(8'h22);
    run_op(16'h000D);                     // high byte, busy starts
    @(negedge clk); ptr_load = 1; ptr_in = 22'h0ABCDE; latch_load = 1; latch_in = 8'h77;
    @(negedge clk); ptr_load = 0; latch_load = 0;
    run_op(16'h000C);                     // R9 held while busy
    idle(8);
    ld_ptr(22'h000200); run_op(16'h0009); run_op(16'h0009); idle(2); // read back
    done_noise = 1; idle(4);              // R8 done ignored when idle
    run_op(16'h0009); idle(2);
    done_noise = 0;
    ld_ptr(22'h000301); ld_latch(8'hC3); run_op(16'h000F); idle(8); // pre-inc write even
    ld_ptr(22'h000300); run_op(16'h000E); idle(8);                  // post-dec write even
    run_op(16'h000B); run_op(16'h000B); idle(3);
    run_cmp = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (timed_out);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule